// File: doc/BRIEF.md
# MMU Fault Status Encoder

This block sits between the address translation logic and the coprocessor register file. Each cycle it may receive several fault verdicts from the translation, domain and permission stages. Each verdict is a strobe, a base fault class, a section-or-page flag, a domain number and the virtual address that caused it. The block also runs its own alignment check on word accesses. It picks the single fault that counts this cycle and encodes it into an 8-bit status value and a 32-bit address value, and it raises an abort toward the core.

The two registers are visible only through a read port selected by `rd_sel`. No path writes them except the fault logic itself. Alignment has first claim on the cycle. After it, the report inputs rank in index order, lowest index first. Any other report in the same cycle is dropped. A non-translation error aborts the access but leaves the registers as they were.

Top module: `mfs_top`

## Requirements
- R1: While `rst` is high at a clock edge, both the status and the address registers become zero and `abort_o` becomes low.
- R2: Base class inputs are encoded as 0 linefetch, 1 translation, 2 other bus error, 3 domain, 4 permission, 5 level-1 walk error, 6 level-2 walk error and 7 non-translation error. With the page flag low, the type codes are linefetch 4, translation 5, bus 8, domain 9 and permission 0xD. A level-1 walk error gives 0xC and a level-2 walk error gives 0xE.
- R3: With the page flag high, the five classes 0 to 4 give their section code with bit 1 set (6, 7, 0xA, 0xB, 0xF). The page flag has no effect on classes 5 and 6.
- R4: A recorded fault puts its type code in status bits 3:0 and its domain in status bits 7:4, and its virtual address in the address register. `rd_sel`=0 returns the status zero-extended to 32 bits, and `rd_sel`=1 returns the address.
- R5: `abort_o` is high in the cycle after every edge at which a fault (of any kind, including a non-translation error) is taken, and low after edges at which none is taken.
- R6: Only one fault is taken per edge. An alignment fault has priority over every report. Among reports, the lowest index that is eligible wins and all others are dropped.
- R7: When `ctl_mmu_on` is low, reports of classes 0 to 6 are ignored: they update no register and raise no abort.
- R8: With `ctl_align_on` high, a valid word access (`acc_is_word`=1) whose address bits 1:0 are not both zero records type 1 with domain 0 and the access address. This holds whatever the value of `ctl_mmu_on`. Byte accesses, and all accesses while `ctl_align_on` is low, never raise it.
- R9: A class-7 report that wins the edge raises the abort but leaves both registers unchanged. Reports that lose to it are still dropped.
- R10: Both registers hold their values across edges at which no fault is taken.
- R11: The status type field never holds 2 or 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_mmu_on | input | 1 | Translation enable; gates classes 0 to 6 |
| ctl_align_on | input | 1 | Alignment check enable |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_is_word | input | 1 | 1 = word access, 0 = byte access |
| acc_addr | input | 32 | Virtual address of the access |
| rpt_valid | input | NUM_SRC | Per-report fault strobe |
| rpt_class | input | 3*NUM_SRC | Per-report base class, 3 bits each |
| rpt_page | input | NUM_SRC | Per-report page flag |
| rpt_domain | input | 4*NUM_SRC | Per-report domain, 4 bits each |
| rpt_vaddr | input | 32*NUM_SRC | Per-report virtual address |
| rd_sel | input | 1 | 0 selects status, 1 selects address |
| rd_data | output | 32 | Read data of the selected register |
| abort_o | output | 1 | Abort to the core, one cycle after the fault edge |

## Verification
The hardest cases to reach are edges where several claims collide. Examples are a misaligned word access arriving together with translation reports, a class-7 report that ranks ahead of a translation fault, and eligible reports that sit behind ones masked off by a low `ctl_mmu_on`. Directed sequences set up each of these collisions on purpose. A long random phase then drives every report input with a high strobe rate and a biased mix of enable settings, so such overlaps happen on most cycles. The reference model decides the winner of each one.

// File: rtl/mfs_pkg.sv
package mfs_pkg;

    localparam int VA_W   = 32;
    localparam int DOM_W  = 4;
    localparam int CODE_W = 4;
    localparam int CLS_W  = 3;
    localparam int FS_W   = DOM_W + CODE_W;

    typedef enum logic [CLS_W-1:0] {
        CLS_LINEFETCH = 3'd0,
        CLS_XLATE     = 3'd1,
        CLS_BUSERR    = 3'd2,
        CLS_DOMAIN    = 3'd3,
        CLS_PERM      = 3'd4,
        CLS_L1WALK    = 3'd5,
        CLS_L2WALK    = 3'd6,
        CLS_NONMMU    = 3'd7
    } fault_class_e;

    localparam logic [CODE_W-1:0] CODE_ALIGN  = 4'h1;
    localparam logic [CODE_W-1:0] CODE_NONMMU = 4'h3;
    localparam logic [CODE_W-1:0] PAGE_BIT    = 4'h2;

    typedef struct packed {
        logic [DOM_W-1:0]  dom;
        logic [CODE_W-1:0] code;
    } fstat_t;

    typedef struct packed {
        logic            vld;
        logic            nonmmu;
        fstat_t          fs;
        logic [VA_W-1:0] va;
    } frec_t;

    // Section code for a class, page variant derived by setting bit 1.
    function automatic logic [CODE_W-1:0] class_code(fault_class_e cls, logic page);
        logic [CODE_W-1:0] c;
        logic              pageable;
        pageable = 1'b1;
        case (cls)
            CLS_LINEFETCH: c = 4'h4;
            CLS_XLATE:     c = 4'h5;
            CLS_BUSERR:    c = 4'h8;
            CLS_DOMAIN:    c = 4'h9;
            CLS_PERM:      c = 4'hD;
            CLS_L1WALK:    begin c = 4'hC; pageable = 1'b0; end
            CLS_L2WALK:    begin c = 4'hE; pageable = 1'b0; end
            default:       begin c = CODE_NONMMU; pageable = 1'b0; end
        endcase
        if (pageable && page)
            c = c | PAGE_BIT;
        return c;
    endfunction

endpackage

// File: rtl/mfs_src_enc.sv
module mfs_src_enc
    import mfs_pkg::*;
(
    input  logic                mmu_on,
    input  logic                valid,
    input  logic [CLS_W-1:0]    cls,
    input  logic                page,
    input  logic [DOM_W-1:0]    dom,
    input  logic [VA_W-1:0]     va,
    output frec_t               rec
);
    fault_class_e cls_e;
    logic         is_nonmmu;

    always_comb begin
        cls_e       = fault_class_e'(cls);
        is_nonmmu   = (cls_e == CLS_NONMMU);
        rec.vld     = valid && (is_nonmmu || mmu_on);
        rec.nonmmu  = is_nonmmu;
        rec.fs.dom  = dom;
        rec.fs.code = class_code(cls_e, page);
        rec.va      = va;
    end
endmodule

// File: rtl/mfs_align_chk.sv
module mfs_align_chk
    import mfs_pkg::*;
(
    input  logic             align_on,
    input  logic             acc_valid,
    input  logic             is_word,
    input  logic [VA_W-1:0]  addr,
    output frec_t            rec
);
    always_comb begin
        rec.vld     = align_on && acc_valid && is_word && (addr[1:0] != 2'b00);
        rec.nonmmu  = 1'b0;
        rec.fs.dom  = '0;
        rec.fs.code = CODE_ALIGN;
        rec.va      = addr;
    end
endmodule

// File: rtl/mfs_first_pick.sv
module mfs_first_pick
    import mfs_pkg::*;
#(
    parameter int NREC = 4
) (
    input  frec_t [NREC-1:0] recs,
    output frec_t            win
);
    always_comb begin
        logic found;
        found = 1'b0;
        win   = '0;
        for (int i = 0; i < NREC; i++) begin
            if (!found && recs[i].vld) begin
                win   = recs[i];
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/mfs_regs.sv
module mfs_regs
    import mfs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  frec_t            win,
    input  logic             rd_sel,
    output logic [VA_W-1:0]  rd_data,
    output fstat_t           fsr_o,
    output logic [VA_W-1:0]  far_o,
    output logic             abort_o
);
    fstat_t          fsr_q;
    logic [VA_W-1:0] far_q;
    logic            abort_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fsr_q   <= '0;
            far_q   <= '0;
            abort_q <= 1'b0;
        end else begin
            abort_q <= win.vld;
            if (win.vld && !win.nonmmu) begin
                fsr_q <= win.fs;
                far_q <= win.va;
            end
        end
    end

    always_comb begin
        rd_data = rd_sel ? far_q : {{(VA_W-FS_W){1'b0}}, fsr_q};
    end

    assign fsr_o   = fsr_q;
    assign far_o   = far_q;
    assign abort_o = abort_q;

    // R11
    type_range_chk: assert property (@(posedge clk) disable iff (rst)
        (fsr_q.code != 4'h2 && fsr_q.code != CODE_NONMMU));

    // R10
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !win.vld |=> ($stable(fsr_q) && $stable(far_q) && !abort_q));

    // R9
    nonmmu_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (win.vld && win.nonmmu) |=> ($stable(fsr_q) && $stable(far_q) && abort_q));
endmodule

// File: rtl/mfs_top.sv
module mfs_top
    import mfs_pkg::*;
#(
    parameter int NUM_SRC = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      ctl_mmu_on,
    input  logic                      ctl_align_on,
    input  logic                      acc_valid,
    input  logic                      acc_is_word,
    input  logic [VA_W-1:0]           acc_addr,
    input  logic [NUM_SRC-1:0]        rpt_valid,
    input  logic [NUM_SRC*CLS_W-1:0]  rpt_class,
    input  logic [NUM_SRC-1:0]        rpt_page,
    input  logic [NUM_SRC*DOM_W-1:0]  rpt_domain,
    input  logic [NUM_SRC*VA_W-1:0]   rpt_vaddr,
    input  logic                      rd_sel,
    output logic [VA_W-1:0]           rd_data,
    output logic                      abort_o
);
    localparam int NREC = NUM_SRC + 1;

    frec_t [NREC-1:0] recs;
    frec_t            win;
    fstat_t           fsr;
    logic [VA_W-1:0]  far;

    mfs_align_chk u_align (
        .align_on  (ctl_align_on),
        .acc_valid (acc_valid),
        .is_word   (acc_is_word),
        .addr      (acc_addr),
        .rec       (recs[0])
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        mfs_src_enc u_enc (
            .mmu_on (ctl_mmu_on),
            .valid  (rpt_valid[g]),
            .cls    (rpt_class[g*CLS_W +: CLS_W]),
            .page   (rpt_page[g]),
            .dom    (rpt_domain[g*DOM_W +: DOM_W]),
            .va     (rpt_vaddr[g*VA_W +: VA_W]),
            .rec    (recs[g+1])
        );
    end

    mfs_first_pick #(.NREC(NREC)) u_pick (
        .recs (recs),
        .win  (win)
    );

    mfs_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .win     (win),
        .rd_sel  (rd_sel),
        .rd_data (rd_data),
        .fsr_o   (fsr),
        .far_o   (far),
        .abort_o (abort_o)
    );

    logic misaligned;
    logic any_nonmmu;
    always_comb begin
        misaligned = ctl_align_on && acc_valid && acc_is_word && (acc_addr[1:0] != 2'b00);
        any_nonmmu = 1'b0;
        for (int i = 0; i < NUM_SRC; i++)
            if (rpt_valid[i] && (rpt_class[i*CLS_W +: CLS_W] == 3'd7))
                any_nonmmu = 1'b1;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (fsr == '0 && far == '0 && !abort_o));

    // R8
    align_fault_chk: assert property (@(posedge clk) disable iff (rst)
        misaligned |=> (fsr == 8'h01 && far == $past(acc_addr) && abort_o));

    // R7
    mmu_off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl_mmu_on && !misaligned && !any_nonmmu) |=> !abort_o);

    // R6
    first_src_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (!misaligned && ctl_mmu_on && rpt_valid[0] && rpt_class[CLS_W-1:0] != 3'd7)
            |=> (far == $past(rpt_vaddr[VA_W-1:0]) && abort_o));
endmodule

// File: tb/tb_mfs_top.sv
`timescale 1ns/1ps
module tb_mfs_top;
    localparam int N = 3;

    logic            clk = 1'b0;
    logic            rst;
    logic            ctl_mmu_on, ctl_align_on, acc_valid, acc_is_word;
    logic [31:0]     acc_addr;
    logic [N-1:0]    rpt_valid, rpt_page;
    logic [N*3-1:0]  rpt_class;
    logic [N*4-1:0]  rpt_domain;
    logic [N*32-1:0] rpt_vaddr;
    logic            rd_sel;
    logic [31:0]     rd_data;
    logic            abort_o;

    int checks = 0;
    int errors = 0;
    int exp_fsr, exp_abort;
    logic [31:0] exp_far;

    always #2.5 clk = ~clk;

    mfs_top #(.NUM_SRC(N)) dut (
        .clk(clk), .rst(rst), .ctl_mmu_on(ctl_mmu_on), .ctl_align_on(ctl_align_on),
        .acc_valid(acc_valid), .acc_is_word(acc_is_word), .acc_addr(acc_addr),
        .rpt_valid(rpt_valid), .rpt_class(rpt_class), .rpt_page(rpt_page),
        .rpt_domain(rpt_domain), .rpt_vaddr(rpt_vaddr), .rd_sel(rd_sel),
        .rd_data(rd_data), .abort_o(abort_o)
    );

    function automatic int ref_code(int c, bit pg);
        int r;
        case (c)
            0: r = 4;
            1: r = 5;
            2: r = 8;
            3: r = 9;
            4: r = 13;
            5: return 12;
            6: return 14;
            default: return 3;
        endcase
        return pg ? r + 2 : r;
    endfunction

    task automatic model_edge();
        bit taken = 0;
        if (rst) begin
            exp_fsr = 0; exp_far = 0; exp_abort = 0;
            return;
        end
        exp_abort = 0;
        if (ctl_align_on && acc_valid && acc_is_word && acc_addr[1:0] != 0) begin
            exp_fsr = 1; exp_far = acc_addr; exp_abort = 1; taken = 1;
        end
        for (int i = 0; i < N; i++) begin
            int c;
            c = int'(rpt_class[i*3 +: 3]);
            if (!taken && rpt_valid[i] && (c == 7 || ctl_mmu_on)) begin
                taken = 1;
                exp_abort = 1;
                if (c != 7) begin
                    exp_fsr = ref_code(c, rpt_page[i]) + 16 * int'(rpt_domain[i*4 +: 4]);
                    exp_far = rpt_vaddr[i*32 +: 32];
                end
            end
        end
    endtask

    task automatic check(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step(string req);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        rd_sel = 1'b0;
        #0.5;
        check(req, "status", rd_data, exp_fsr);
        rd_sel = 1'b1;
        #0.5;
        check(req, "address", rd_data, exp_far);
        check(req, "abort", abort_o, exp_abort);
    endtask

    task automatic idle();
        acc_valid = 0; acc_is_word = 0; acc_addr = 0;
        rpt_valid = 0; rpt_class = 0; rpt_page = 0; rpt_domain = 0; rpt_vaddr = 0;
    endtask

    task automatic rpt(int i, int c, bit pg, int d, logic [31:0] va);
        rpt_valid[i] = 1'b1;
        rpt_class[i*3 +: 3] = 3'(c);
        rpt_page[i] = pg;
        rpt_domain[i*4 +: 4] = 4'(d);
        rpt_vaddr[i*32 +: 32] = va;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rd_sel = 0; rst = 1; ctl_mmu_on = 0; ctl_align_on = 0;
        idle();
        @(negedge clk);
        // R1 reset state
        step("R1");
        rst = 0;
        ctl_mmu_on = 1;
        // R2 section codes, R3 page codes, R4 field placement
        for (int c = 0; c < 7; c++) begin
            for (int pg = 0; pg < 2; pg++) begin
                idle();
                rpt(0, c, pg[0], c + 5 * pg, 32'h1000_0000 + c * 16 + pg);
                step(pg ? "R3" : "R2");
            end
        end
        // R10 hold with nothing reported
        idle();
        step("R10");
        step("R10");
        // R8 alignment
        ctl_align_on = 1;
        acc_valid = 1; acc_is_word = 1; acc_addr = 32'hCAFE_0002;
        step("R8");
        acc_addr = 32'hCAFE_0004;
        step("R8");
        acc_is_word = 0; acc_addr = 32'hCAFE_0007;
        step("R8");
        ctl_mmu_on = 0; acc_is_word = 1; acc_addr = 32'h0000_0011;
        step("R8");
        ctl_align_on = 0; acc_addr = 32'h0000_0023;
        step("R8");
        // R7 translation disabled
        idle();
        rpt(0, 1, 0, 3, 32'hDEAD_0000);
        rpt(2, 4, 1, 7, 32'hDEAD_0100);
        step("R7");
        // R9 non-translation error, also with translation off
        rpt(1, 7, 0, 2, 32'hBEEF_0000);
        step("R9");
        // R6 priority: masked reports let a later one win
        ctl_mmu_on = 1;
        idle();
        rpt(1, 3, 1, 9, 32'h2222_0000);
        rpt(2, 2, 0, 4, 32'h3333_0000);
        step("R6");
        // R9 non-translation first blocks later reports
        idle();
        rpt(0, 7, 0, 1, 32'h4444_0000);
        rpt(1, 1, 0, 6, 32'h5555_0000);
        step("R9");
        // R6 alignment beats reports
        ctl_align_on = 1; acc_valid = 1; acc_is_word = 1; acc_addr = 32'h6666_0001;
        rpt(0, 4, 1, 15, 32'h7777_0000);
        step("R6");
        // R5 abort pulse drops after an idle edge
        idle();
        step("R5");
        // R6/R5/R11 random collisions
        for (int k = 0; k < 600; k++) begin
            ctl_mmu_on   = ($urandom_range(0, 4) != 0);
            ctl_align_on = $urandom_range(0, 1) != 0;
            acc_valid    = $urandom_range(0, 1) != 0;
            acc_is_word  = $urandom_range(0, 1) != 0;
            acc_addr     = $urandom;
            for (int i = 0; i < N; i++) begin
                rpt_valid[i]          = ($urandom_range(0, 2) != 0);
                rpt_class[i*3 +: 3]   = 3'($urandom_range(0, 7));
                rpt_page[i]           = $urandom_range(0, 1) != 0;
                rpt_domain[i*4 +: 4]  = 4'($urandom_range(0, 15));
                rpt_vaddr[i*32 +: 32] = $urandom;
            end
            step("R6");
        end
        // R1 reset mid-run
        idle();
        rst = 1;
        rpt(0, 0, 0, 5, 32'h9999_0000);
        step("R1");
        rst = 0;
        idle();
        step("R10");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule